// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block paces one successive-approximation conversion from the CPU clock alone. Two 2-bit codes, read from the top of a 16-bit control word, choose how many CPU cycles make up one period of the basic conversion clock and how many of those periods the input sampling phase lasts. A one-cycle start pulse launches a conversion: the block raises a sample-enable for the programmed sampling window, then walks through one step per result bit, strobing each step with its bit index. It shifts a comparator decision in on every strobe, most significant bit first, and finally publishes the word with a one-cycle done pulse.

The basic clock is never a real clock. It is a single-cycle tick from a counter that is cleared when a conversion is accepted, so every phase is an exact multiple of the chosen ratio. The analog comparator, the capacitor array and the bus that writes the control word sit outside the block. The comparator decision enters as a plain input bit.

Top module: `adc_conv_timer`

## Requirements
- R1: After a synchronous active-high reset, busy_o, sample_en_o, step_strobe_o and done_o are low and result_o is zero.
- R2: The divider code in ctrl_word_i[15:14] sets the basic-clock period in CPU cycles: 00 gives 4, 01 gives 2, 10 gives 16, 11 gives 8. Consecutive step strobes are exactly one such period apart.
- R3: The sample code in ctrl_word_i[13:12] sets the sampling window to 8 (00), 16 (01), 32 (10) or 64 (11) basic-clock periods. sample_en_o is high from the cycle after the start is accepted, for exactly that many periods times the divider ratio in CPU cycles.
- R4: After sampling comes exactly RES_BITS steps of one basic-clock period each. step_strobe_o is high on the last CPU cycle of each step, and step_idx_o counts down from RES_BITS-1 to 0.
- R5: On each strobe the block captures cmp_bit_i as the bit named by step_idx_o. The finished word appears on result_o, with bit RES_BITS-1 decided first.
- R6: done_o is high for exactly one cycle, the cycle after the final strobe. busy_o is already low in that cycle, and result_o changes only at that point.
- R7: Both codes are latched when a start is accepted. Changes to ctrl_word_i while busy do not alter the running conversion's timing.
- R8: A start pulse while busy_o is high is ignored. It neither restarts nor lengthens the conversion.
- R9: ctrl_word_i[11:0] has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request, one cycle |
| ctrl_word_i | input | 16 | Control word; [15:14] divider code, [13:12] sample code |
| cmp_bit_i | input | 1 | Comparator decision for the current step |
| sample_en_o | output | 1 | High during the sampling window |
| step_strobe_o | output | 1 | Last cycle of a conversion step |
| step_idx_o | output | 4 | Bit index of the current step |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 10 | Converted word |

## Verification
Take C as the cycle after the edge that accepts the start, D as the divider ratio and S as the sample multiple. Then sample_en_o is due high from C through C+S·D-1. Strobe k falls in cycle C+S·D+k·D-1. done_o and the new result_o are due in cycle C+(S+RES_BITS)·D, one register after the final strobe. The bench drives inputs and samples outputs on the falling edge. It counts cycles from C and compares each event with the cycle number computed from these formulas. It sets the comparator bit from the currently shown step index, so the value is in place before the capturing edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int DIV_CNT_W = 4;
    localparam int SMP_CNT_W = 6;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_SAMPLE = 2'd1,
        SEQ_STEP   = 2'd2
    } seq_state_e;

    // last count value of the divider (ratio minus one); the code order is not monotonic
    function automatic logic [DIV_CNT_W-1:0] div_last(input logic [1:0] code);
        case (code)
            2'b00:   div_last = 4'd3;
            2'b01:   div_last = 4'd1;
            2'b10:   div_last = 4'd15;
            default: div_last = 4'd7;
        endcase
    endfunction

    // last basic-clock period index of the sampling window
    function automatic logic [SMP_CNT_W-1:0] smp_last(input logic [1:0] code);
        case (code)
            2'b00:   smp_last = 6'd7;
            2'b01:   smp_last = 6'd15;
            2'b10:   smp_last = 6'd31;
            default: smp_last = 6'd63;
        endcase
    endfunction

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div
    import adc_seq_pkg::*;
#(
    parameter int CNT_W = DIV_CNT_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr_i,
    input  logic [1:0] sel_i,
    output logic       tick_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_reg_t;

    div_reg_t         div_d, div_q;
    logic [CNT_W-1:0] last_cnt;

    always_comb begin
        last_cnt = CNT_W'(div_last(sel_i));
        tick_o   = (div_q.cnt == last_cnt);
        div_d    = div_q;
        if (clr_i || tick_o) begin
            div_d.cnt = '0;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    // every ratio is at least two, so ticks are never adjacent
    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);

endmodule

// File: rtl/adc_phase_fsm.sv
module adc_phase_fsm
    import adc_seq_pkg::*;
#(
    parameter int RES_BITS = 10,
    localparam int IDX_W = (RES_BITS > 1) ? $clog2(RES_BITS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             tick_i,
    input  logic [1:0]       tc_i,
    input  logic [1:0]       st_i,
    output logic             accept_o,
    output logic [1:0]       div_sel_o,
    output logic             sample_en_o,
    output logic             step_strobe_o,
    output logic             last_step_o,
    output logic [IDX_W-1:0] step_idx_o,
    output logic             busy_o
);

    typedef struct packed {
        seq_state_e           state;
        logic [1:0]           tc;
        logic [1:0]           st;
        logic [SMP_CNT_W-1:0] smp_cnt;
        logic [IDX_W-1:0]     idx;
    } fsm_reg_t;

    fsm_reg_t fsm_d, fsm_q;

    always_comb begin
        fsm_d         = fsm_q;
        accept_o      = (fsm_q.state == SEQ_IDLE) && start_i;
        div_sel_o     = fsm_q.tc;
        busy_o        = (fsm_q.state != SEQ_IDLE);
        sample_en_o   = (fsm_q.state == SEQ_SAMPLE);
        step_strobe_o = (fsm_q.state == SEQ_STEP) && tick_i;
        last_step_o   = step_strobe_o && (fsm_q.idx == '0);
        step_idx_o    = fsm_q.idx;

        case (fsm_q.state)
            SEQ_IDLE: begin
                if (start_i) begin
                    fsm_d.state   = SEQ_SAMPLE;
                    fsm_d.tc      = tc_i;
                    fsm_d.st      = st_i;
                    fsm_d.smp_cnt = '0;
                    fsm_d.idx     = IDX_W'(RES_BITS - 1);
                end
            end
            SEQ_SAMPLE: begin
                if (tick_i) begin
                    if (fsm_q.smp_cnt == smp_last(fsm_q.st)) begin
                        fsm_d.state = SEQ_STEP;
                        fsm_d.idx   = IDX_W'(RES_BITS - 1);
                    end else begin
                        fsm_d.smp_cnt = fsm_q.smp_cnt + 1'b1;
                    end
                end
            end
            SEQ_STEP: begin
                if (tick_i) begin
                    if (fsm_q.idx == '0) begin
                        fsm_d.state = SEQ_IDLE;
                    end else begin
                        fsm_d.idx = fsm_q.idx - 1'b1;
                    end
                end
            end
            default: fsm_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q       <= '0;
            fsm_q.state <= SEQ_IDLE;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    // latched codes hold for the whole conversion
    assert_codes_held_R7: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> (!busy_o || (fsm_q.tc == $past(fsm_q.tc) && fsm_q.st == $past(fsm_q.st))));

    // sampling only ever begins from idle
    assert_no_restart_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(sample_en_o) |-> $past(!busy_o));

    // the index on a strobe stays in range
    assert_idx_range_R4: assert property (@(posedge clk) disable iff (rst)
        step_strobe_o |-> (step_idx_o <= IDX_W'(RES_BITS - 1)));

endmodule

// File: rtl/adc_sar_reg.sv
module adc_sar_reg #(
    parameter int RES_BITS = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr_i,
    input  logic                strobe_i,
    input  logic                last_i,
    input  logic                bit_i,
    output logic [RES_BITS-1:0] result_o,
    output logic                done_o
);

    typedef struct packed {
        logic [RES_BITS-1:0] work;
        logic [RES_BITS-1:0] result;
        logic                done;
    } sar_reg_t;

    sar_reg_t            sar_d, sar_q;
    logic [RES_BITS-1:0] shifted;

    always_comb begin
        sar_d      = sar_q;
        sar_d.done = 1'b0;
        shifted    = RES_BITS'({sar_q.work, bit_i});
        if (clr_i) begin
            sar_d.work = '0;
        end else if (strobe_i) begin
            sar_d.work = shifted;
            if (last_i) begin
                sar_d.result = shifted;
                sar_d.done   = 1'b1;
            end
        end
        result_o = sar_q.result;
        done_o   = sar_q.done;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sar_q <= '0;
        end else begin
            sar_q <= sar_d;
        end
    end

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_result_on_done_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(sar_q.result) |-> sar_q.done);

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
    import adc_seq_pkg::*;
#(
    parameter int RES_BITS = 10,
    parameter int CTRL_W   = 16,
    parameter int TC_LSB   = 14,
    parameter int ST_LSB   = 12,
    localparam int IDX_W   = (RES_BITS > 1) ? $clog2(RES_BITS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [CTRL_W-1:0]   ctrl_word_i,
    input  logic                cmp_bit_i,
    output logic                sample_en_o,
    output logic                step_strobe_o,
    output logic [IDX_W-1:0]    step_idx_o,
    output logic                busy_o,
    output logic                done_o,
    output logic [RES_BITS-1:0] result_o
);

    logic       accept;
    logic       tick;
    logic       last_step;
    logic [1:0] div_sel;
    logic [1:0] tc_code;
    logic [1:0] st_code;
    logic       ctrl_unused;

    assign tc_code     = ctrl_word_i[TC_LSB +: 2];
    assign st_code     = ctrl_word_i[ST_LSB +: 2];
    assign ctrl_unused = ^ctrl_word_i[ST_LSB-1:0];

    adc_clk_div #(
        .CNT_W (DIV_CNT_W)
    ) div_i (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (accept),
        .sel_i  (div_sel),
        .tick_o (tick)
    );

    adc_phase_fsm #(
        .RES_BITS (RES_BITS)
    ) fsm_i (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .tick_i        (tick),
        .tc_i          (tc_code),
        .st_i          (st_code),
        .accept_o      (accept),
        .div_sel_o     (div_sel),
        .sample_en_o   (sample_en_o),
        .step_strobe_o (step_strobe_o),
        .last_step_o   (last_step),
        .step_idx_o    (step_idx_o),
        .busy_o        (busy_o)
    );

    adc_sar_reg #(
        .RES_BITS (RES_BITS)
    ) sar_i (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (accept),
        .strobe_i (step_strobe_o),
        .last_i   (last_step),
        .bit_i    (cmp_bit_i),
        .result_o (result_o),
        .done_o   (done_o)
    );

    assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    assert_steps_follow_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(sample_en_o) |-> busy_o);

    assert_strobe_busy_R4: assert property (@(posedge clk) disable iff (rst)
        step_strobe_o |-> (busy_o && !sample_en_o));

endmodule

// File: tb/adc_conv_timer_tb_top.sv
module adc_conv_timer_tb_top;

    localparam int RES   = 10;
    localparam int IDX_W = $clog2(RES);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [15:0]      ctrl_word_i = '0;
    logic             cmp_bit_i = 1'b0;
    logic             sample_en_o;
    logic             step_strobe_o;
    logic [IDX_W-1:0] step_idx_o;
    logic             busy_o;
    logic             done_o;
    logic [RES-1:0]   result_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    adc_conv_timer dut_i (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .ctrl_word_i   (ctrl_word_i),
        .cmp_bit_i     (cmp_bit_i),
        .sample_en_o   (sample_en_o),
        .step_strobe_o (step_strobe_o),
        .step_idx_o    (step_idx_o),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .result_o      (result_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int ratio_of(input logic [1:0] code);
        case (code)
            2'b00:   return 4;
            2'b01:   return 2;
            2'b10:   return 16;
            default: return 8;
        endcase
    endfunction

    task automatic test_reset();
        @(negedge clk);
        check(busy_o == 1'b0, "R1", "busy after reset", busy_o, 0);
        check(sample_en_o == 1'b0, "R1", "sample_en after reset", sample_en_o, 0);
        check(step_strobe_o == 1'b0, "R1", "strobe after reset", step_strobe_o, 0);
        check(done_o == 1'b0, "R1", "done after reset", done_o, 0);
        check(result_o == '0, "R1", "result after reset", result_o, 0);
    endtask

    // one conversion; mess=1 rewrites the codes and re-pulses start while busy (R7, R8)
    task automatic run_conv(input logic [1:0] tc, input logic [1:0] st,
                            input logic [RES-1:0] pat, input logic [11:0] low,
                            input bit mess, input string tag);
        int d;
        int s;
        int c;
        int nsmp;
        int nstr;
        int pos_err;
        int idx_err;
        int done_c;
        int first_smp;
        int busy_done;
        d = ratio_of(tc);
        s = 8 << st;
        nsmp = 0; nstr = 0; pos_err = 0; idx_err = 0; done_c = -1;
        first_smp = 0; busy_done = 1;
        @(negedge clk);
        ctrl_word_i = {tc, st, low};
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        c = 1;
        while (done_c < 0 && c < 3000) begin
            if (sample_en_o) begin
                nsmp++;
                if (c == 1) first_smp = 1;
            end
            if (step_strobe_o) begin
                nstr++;
                if (c != s * d + nstr * d) pos_err++;
                if (int'(step_idx_o) != RES - nstr) idx_err++;
            end
            if (done_o) begin
                done_c = c;
                busy_done = busy_o;
            end
            cmp_bit_i = (int'(step_idx_o) < RES) ? pat[step_idx_o] : 1'b0;
            if (mess) begin
                if (c == 2) ctrl_word_i = {~tc, ~st, ~low};
                start_i = (c == 5 || c == s * d + d + 1);
            end
            @(negedge clk);
            c++;
        end
        start_i = 1'b0;
        check(nsmp == s * d, {tag, " R3"}, "sample cycles", nsmp, s * d);
        check(first_smp == 1, {tag, " R3"}, "sample starts next cycle", first_smp, 1);
        check(nstr == RES, {tag, " R4"}, "strobe count", nstr, RES);
        check(pos_err == 0, {tag, " R2"}, "misplaced strobes", pos_err, 0);
        check(idx_err == 0, {tag, " R4"}, "wrong step index", idx_err, 0);
        check(result_o == pat, {tag, " R5"}, "result", result_o, pat);
        check(done_c == (s + RES) * d + 1, {tag, " R6"}, "done cycle", done_c, (s + RES) * d + 1);
        check(busy_done == 0, {tag, " R6"}, "busy at done", busy_done, 0);
        check(done_o == 1'b0, {tag, " R6"}, "done one cycle", done_o, 0);
        check(busy_o == 1'b0, {tag, " R8"}, "idle after done", busy_o, 0);
    endtask

    task automatic test_dividers();
        run_conv(2'b00, 2'b00, 10'h2A5, 12'h000, 1'b0, "R2 div4");
        run_conv(2'b01, 2'b00, 10'h3FF, 12'hABC, 1'b0, "R2 div2 R9");
        run_conv(2'b10, 2'b00, 10'h000, 12'hFFF, 1'b0, "R2 div16 R9");
        run_conv(2'b11, 2'b00, 10'h155, 12'h123, 1'b0, "R2 div8 R9");
    endtask

    task automatic test_samples();
        run_conv(2'b01, 2'b01, 10'h201, 12'h000, 1'b0, "R3 s16");
        run_conv(2'b01, 2'b10, 10'h0F0, 12'h5A5, 1'b0, "R3 s32");
        run_conv(2'b10, 2'b11, 10'h333, 12'h000, 1'b0, "R3 s64 slowest");
    endtask

    task automatic test_busy_writes();
        run_conv(2'b11, 2'b01, 10'h1C7, 12'h0F0, 1'b1, "R7 R8 busy writes");
        run_conv(2'b00, 2'b10, 10'h38E, 12'h000, 1'b1, "R7 R8 busy writes b");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_dividers();
        test_samples();
        test_busy_writes();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule